// File: doc/BRIEF.md
# Programmable One-Shot Countdown Timer

This block is the countdown timer of a per-core interrupt controller. Software programs a divide code that sets how many input clocks make up one count, then writes a start value. The timer counts that value down at the divided rate and, when it reaches zero, raises a single-cycle expiry pulse and halts. The remaining count can be read back at any time while the timer runs.

A free-running prescaler sets the count boundaries. A start write that falls between two boundaries does not reset the prescaler. Its first count is therefore a partial one, and the readback counts a partial period as a whole count. A change to the divide code takes effect only when the prescaler next wraps, so the count in progress is never cut short.

Top module: `cd_timer`

## Requirements
- R1: The divide code is the 3-bit value {div[3], div[1:0]}. The ratio in input clocks per count is 2 to the power ((code + 1) mod 8). Code 0 gives 2, code 6 gives 128 and code 7 gives 1.
- R2: The divide register is at address 2. A write keeps only bits 3, 1 and 0 (mask 0xB), and every other bit reads back as zero. Its reset value is zero.
- R3: A nonzero write to the start register (address 0) loads the counter with that value and restarts the countdown, replacing any countdown in progress.
- R4: The remaining-count register (address 1) is read-only. A write to it changes neither the count nor the timing.
- R5: A read of address 1 returns the whole counts left, with a partial count rounded up. Right after a start write it returns the written value, and it falls by one at each prescaler wrap.
- R6: When no countdown is active, address 1 reads as zero. This holds after reset and after expiry.
- R7: The prescaler is not reset by a start write. The first count ends at the next prescaler wrap, so with a start value N and ratio r the expiry falls between (N-1)*r+1 and N*r clocks after the write.
- R8: A new divide code takes effect at the next wrap of the prescaler running at the old ratio, and the prescaler restarts from zero at that wrap.
- R9: Writing zero to the start register stops the timer at once, and no expiry pulse follows.
- R10: On expiry `expired` is high for exactly one clock, on the edge where the count goes from 1 to 0. The counter then stays at zero.
- R11: Reads are registered: `rd_data` updates on the edge where `rd_en` is sampled high. Address 0 returns the last start value written, and address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 start, 1 remaining, 2 divide, 3 unused |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Registered read data |
| expired | output | 1 | One-cycle expiry pulse |

## Verification
The bench builds the block with the default 32-bit count. It uses small start values, so each countdown finishes in at most a few hundred clocks, even at the slowest divide ratio of 128. Exact cycle checks run at ratio 1, where each edge is a count boundary. All eight divide codes are used with a start value of 4, which makes the expiry windows for neighbouring ratios disjoint, so every decoded ratio is told apart. For the mid-countdown divide change, the bench first runs the prescaler at ratio 1 so that the wrap phase at ratio 128 is known. It then checks the expiry to the exact cycle.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned SHIFT_W = 3;
  localparam int unsigned DIV_W   = 4;

  localparam logic [SEL_W-1:0] SEL_START  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_REMAIN = 2'd1;
  localparam logic [SEL_W-1:0] SEL_DIV    = 2'd2;

  // Shift amount for a stored divide code: ({b3,b1,b0} + 1) mod 8.
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIV_W-1:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
#(
  parameter int unsigned SW = SHIFT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] shift_req,
  output logic          tick
);
  localparam int unsigned PRE_W = (1 << SW) - 1;

  logic [SW-1:0]    shift_act;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] lim;

  assign lim  = ~({PRE_W{1'b1}} << shift_act);
  assign tick = (pre == lim);

  // The shift in use changes only at a wrap, so the period in progress completes.
  always_ff @(posedge clk) begin
    if (rst) begin
      shift_act <= SW'(1);
      pre       <= '0;
    end else if (tick) begin
      shift_act <= shift_req;
      pre       <= '0;
    end else begin
      pre <= pre + PRE_W'(1);
    end
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (tick && (cnt != '0)) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) expired <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cd_timer.sv
module cd_timer
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output logic             expired
);
  logic [CNT_W-1:0] start_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cur_cnt;
  logic             tick;
  logic             load;

  assign load = wr_en && (addr == SEL_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      div_q   <= '0;
    end else if (wr_en) begin
      if (addr == SEL_START) start_q <= wr_data;
      if (addr == SEL_DIV)   div_q   <= {wr_data[3], 1'b0, wr_data[1:0]};
    end
  end

  cdt_prescaler #(.SW(SHIFT_W)) i_pre (
    .clk       (clk),
    .rst       (rst),
    .shift_req (div_shift(div_q)),
    .tick      (tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (load),
    .load_val (wr_data),
    .cnt      (cur_cnt),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (addr)
        SEL_START:  rd_data <= start_q;
        SEL_REMAIN: rd_data <= cur_cnt;
        SEL_DIV:    rd_data <= CNT_W'(div_q);
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] rd_data,
  input logic [CNT_W-1:0] cur,
  input logic             expired
);
  AST_DIV_READ_MASK: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == SEL_DIV) |=> ((rd_data & ~CNT_W'(11)) == '0)); // R2

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == SEL_START) |=> (cur == $past(wr_data))); // R3

  AST_REMAIN_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == SEL_REMAIN) |=> (cur <= $past(cur))); // R4

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == SEL_START) |=> (cur == $past(cur) || cur == $past(cur) - CNT_W'(1))); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cur == '0 && !(wr_en && addr == SEL_START)) |=> (cur == '0)); // R6

  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == SEL_START && wr_data == '0) |=> !expired); // R9

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    expired |=> !expired); // R10

  AST_HALT_ZERO: assert property (@(posedge clk) disable iff (rst)
    expired |-> (cur == '0)); // R10
endmodule

bind cd_timer cdt_checker #(.CNT_W(CNT_W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .cur     (cur_cnt),
  .expired (expired)
);

// File: tb/test_cd_timer.sv
module test_cd_timer;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         expired;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cd_timer #(.CNT_W(W)) i_cd_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .expired(expired)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Tasks start and end at a falling edge; exactly one rising edge lies between.
  task automatic do_write(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [W-1:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count edges after a start write until the pulse; returns 0 if none appears.
  task automatic wait_expiry(input int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (expired) begin k = i; break; end
    end
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    chk(rd_data == '0, "R11 rd_data after reset", rd_data, 0);
    chk(expired == 1'b0, "R10 expired after reset", W'(expired), 0);
    do_read(2'd1, v); chk(v == '0, "R6 remaining after reset", v, 0);
    do_read(2'd2, v); chk(v == '0, "R2 divide after reset", v, 0);
    do_read(2'd3, v); chk(v == '0, "R11 unused address", v, 0);
  endtask

  task automatic t_div_mask();
    logic [W-1:0] v;
    do_write(2'd2, 32'hFFFF_FFFF); do_read(2'd2, v);
    chk(v == 32'hB, "R2 divide mask all ones", v, 32'hB);
    do_write(2'd2, 32'h0000_0F04); do_read(2'd2, v);
    chk(v == 32'h0, "R2 divide mask bit2 only", v, 0);
    do_write(2'd2, 32'hB); idle(10);
  endtask

  task automatic t_oneshot_r1();
    logic [W-1:0] v;
    do_write(2'd0, 32'd6);
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      chk(expired == (k == 6), $sformatf("R10 pulse at edge %0d", k), W'(expired), W'(k == 6));
    end
    do_read(2'd1, v); chk(v == '0, "R6 remaining after expiry", v, 0);
    do_read(2'd0, v); chk(v == 32'd6, "R11 start readback", v, 6);
  endtask

  task automatic t_readout_r1();
    logic [W-1:0] v;
    bit seen;
    do_write(2'd0, 32'd10);
    do_read(2'd1, v); chk(v == 32'd10, "R5 remaining right after start", v, 10);
    do_read(2'd1, v); chk(v == 32'd9, "R5 remaining one count later", v, 9);
    do_write(2'd1, 32'h55);
    do_read(2'd1, v); chk(v == 32'd7, "R4 remaining after write to it", v, 7);
    do_write(2'd0, 32'd0);
    seen = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (expired) seen = 1'b1;
    end
    chk(!seen, "R9 no pulse after zero start", W'(seen), 0);
    do_read(2'd1, v); chk(v == '0, "R9 remaining after zero start", v, 0);
  endtask

  task automatic t_restart_r1();
    int k;
    do_write(2'd0, 32'd20);
    idle(3);
    do_write(2'd0, 32'd5);
    wait_expiry(40, k);
    chk(k == 5, "R3 restart replaces countdown", W'(k), 5);
  endtask

  task automatic t_ratios();
    int k;
    for (int code = 0; code < 8; code++) begin
      int r;
      logic [W-1:0] cfg;
      r   = 1 << ((code + 1) % 8);
      cfg = W'({code[2], 1'b0, code[1:0]});
      do_write(2'd2, cfg);
      idle(140);
      do_write(2'd0, 32'd4);
      wait_expiry(600, k);
      chk(k >= 3 * r + 1 && k <= 4 * r, $sformatf("R1 code %0d ratio %0d", code, r), W'(k), W'(4 * r));
    end
  endtask

  task automatic t_partial_first();
    int k;
    logic [W-1:0] v;
    do_write(2'd2, 32'h2);
    idle(20);
    for (int ph = 0; ph < 3; ph++) begin
      idle(ph);
      do_write(2'd0, 32'd3);
      do_read(2'd1, v);
      chk(v == 32'd3 || v == 32'd2, "R5 readback rounds partial up", v, 3);
      wait_expiry(40, k);
      chk(k >= 17 && k <= 24, $sformatf("R7 phase %0d expiry window", ph), W'(k), 24);
    end
  endtask

  task automatic t_midchange();
    int k;
    bit early;
    do_write(2'd2, 32'hB);
    idle(10);
    do_write(2'd2, 32'hA);
    do_write(2'd0, 32'd3);
    k = 0; early = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); k++;
      if (expired) early = 1'b1;
    end
    do_write(2'd2, 32'hB); k++;
    if (expired) early = 1'b1;
    for (int i = 0; i < 300 && !expired; i++) begin
      @(negedge clk); k++;
    end
    chk(!early && k == 130, "R8 divide change waits for wrap", W'(k), 130);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_div_mask();
    t_oneshot_r1();
    t_readout_r1();
    t_restart_r1();
    t_ratios();
    t_partial_first();
    t_midchange();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule